// File: doc/BRIEF.md
# I2C Step Master

This block is an I2C bus master that carries out exactly one bus action each time software releases it. The possible actions are a START condition, a repeated START, one byte shifted out (an address or data) with the acknowledge bit read back, one byte shifted in with an acknowledge or a not-acknowledge sent, and a STOP condition. Software writes a data register and a control register. The block performs the requested action. It then raises a step-done flag and posts a one-byte status code, and it holds SCL low until software writes a 1 to the flag.

Bit timing comes from `tick`, a one-cycle strobe that marks each quarter of a bit period. Each bit cell has four phases: SCL low with SDA set, SCL released, SCL released after SDA has been sampled, and SCL low again. A slave that holds SCL low stretches the released phase. Both bus lines are open-drain. A 1 on `scl_oe` or `sda_oe` pulls the line low, and `scl_in` and `sda_in` carry the levels on the wires.

Control register bits: 6 enables the bus, 5 requests a START, 4 requests a STOP, 3 is the step-done flag, and 2 enables the acknowledge for received bytes. Bits 7, 1 and 0 always read 0. `reg_sel` picks the target of a write: 0 is control, 1 is data, and 2 is the soft reset (any value written).

Top module: `i2c_step_master`

## Requirements
- R1: After reset, `status_out` is 0xF8, `irq` is 0, `ctrl_out` is 0x00, and neither line is pulled low.
- R2: With bit 6 set, writing bit 5 while idle produces SDA falling while SCL is high, followed by SCL held low. The step then completes with status 0x08 and the flag set, and bit 5 reads back as 0.
- R3: The flag (bit 3) rises when a step ends and stays set while SCL is held low. Writing 1 to bit 3 clears it and releases the next step. Writing 0 to bit 3 leaves the flag set, and ticks then change nothing.
- R4: The first byte after a START or repeated START is an address. It is sent MSB first from the data register, and bit 0 gives the direction (1 = read). The resulting status is 0x18 or 0x20 for a write address that was acknowledged or not, and 0x40 or 0x48 for a read address that was acknowledged or not.
- R5: After a write address, each released step shifts out the data register MSB first. Status is 0x28 when the slave pulls SDA low on the ninth clock and 0x30 when it does not.
- R6: After an acknowledged read address, each step samples eight bits MSB first while SCL is high and places them in `data_out`. On the ninth clock the block drives SDA low when bit 2 is set and releases it when bit 2 is clear. Status is 0x50 for an acknowledged byte and 0x58 for a not-acknowledged byte.
- R7: Setting bit 5 while the bus is held produces a repeated START with status 0x10. The next byte is treated as an address.
- R8: Setting bit 4 while the bus is held produces SDA rising while SCL is high. Bit 4 then clears itself, status returns to 0xF8, both lines are released, and the flag is not raised.
- R9: Any write with `reg_sel` = 2 returns the engine to idle in the next cycle: status 0xF8, flag, bit 5 and bit 4 all 0, and both lines released, even in the middle of a byte.
- R10: While bit 6 is clear, requests are not acted on: no flag, status stays 0xF8, and both lines stay released.
- R11: While a slave holds SCL low during the released phase, ticks do not advance the bit cell.
- R12: If software writes 1 to the flag in the same cycle that a step completes, the flag still ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Quarter-bit strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Write target: 0 control, 1 data, 2 soft reset |
| wdata | input | 8 | Write data |
| ctrl_out | output | 8 | Control register readback |
| data_out | output | 8 | Data register (last received byte after a read) |
| status_out | output | 8 | Step status code |
| irq | output | 1 | Step-done flag |
| scl_oe | output | 1 | Pull SCL low |
| scl_in | input | 1 | SCL wire level |
| sda_oe | output | 1 | Pull SDA low |
| sda_in | input | 1 | SDA wire level |

## Verification
Two events can land in the same cycle: the hardware setting the flag when a step finishes, and a software write that clears the flag. The bench provokes this by issuing the final tick of a read byte in the same cycle as a control write with bit 3 set. A behavioural model running in the bench applies the software clear first and the completion second. That model is compared with `irq` and `status_out` on every clock, and the flag must still read 1 afterwards. Clock stretching is included in the same comparison: ticks given while the slave holds SCL low are dropped by the model, so any advance of the bit cell during the stretch shows up as a mismatch in completion timing.

// File: rtl/i2c_step_master.sv
module i2c_step_master (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       reg_wr,
  input  logic [1:0] reg_sel,
  input  logic [7:0] wdata,
  output logic [7:0] ctrl_out,
  output logic [7:0] data_out,
  output logic [7:0] status_out,
  output logic       irq,
  output logic       scl_oe,
  input  logic       scl_in,
  output logic       sda_oe,
  input  logic       sda_in
);
  localparam logic [7:0] C_START  = 8'h08;
  localparam logic [7:0] C_RSTART = 8'h10;
  localparam logic [7:0] C_AW_ACK = 8'h18;
  localparam logic [7:0] C_AW_NAK = 8'h20;
  localparam logic [7:0] C_DW_ACK = 8'h28;
  localparam logic [7:0] C_DW_NAK = 8'h30;
  localparam logic [7:0] C_AR_ACK = 8'h40;
  localparam logic [7:0] C_AR_NAK = 8'h48;
  localparam logic [7:0] C_DR_ACK = 8'h50;
  localparam logic [7:0] C_DR_NAK = 8'h58;
  localparam logic [7:0] C_IDLE   = 8'hF8;
  localparam int B_EN = 6, B_STA = 5, B_STO = 4, B_FLG = 3, B_ACK = 2;
  localparam logic [3:0] LAST_BIT = 4'd8;

  typedef enum logic [2:0] {IDLE, HOLD, GEN_START, GEN_STOP, XFER} state_t;

  state_t     st;
  logic [1:0] ph;
  logic [3:0] bitn;
  logic       en, sta, sto, flag, ack_en;
  logic       scl_lo, sda_lo;
  logic       rep, addr_next, rd_mode, is_addr, is_rd, addr_rw, ackbit;
  logic [7:0] data_r, tx, shin, status, done_code;

  wire wr_ctl = reg_wr && reg_sel == 2'd0;
  wire wr_dat = reg_wr && reg_sel == 2'd1;
  wire wr_rst = reg_wr && reg_sel == 2'd2;
  wire adv    = tick && !(ph == 2'd1 && !scl_in);

  assign ctrl_out   = {1'b0, en, sta, sto, flag, ack_en, 2'b00};
  assign data_out   = data_r;
  assign status_out = status;
  assign irq        = flag;
  assign scl_oe     = scl_lo;
  assign sda_oe     = sda_lo;

  always_comb begin
    if (is_addr)
      done_code = addr_rw ? (ackbit ? C_AR_NAK : C_AR_ACK) : (ackbit ? C_AW_NAK : C_AW_ACK);
    else if (is_rd)
      done_code = ackbit ? C_DR_NAK : C_DR_ACK;
    else
      done_code = ackbit ? C_DW_NAK : C_DW_ACK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; ph <= 2'd0; bitn <= 4'd0;
      en <= 1'b0; sta <= 1'b0; sto <= 1'b0; flag <= 1'b0; ack_en <= 1'b0;
      scl_lo <= 1'b0; sda_lo <= 1'b0;
      rep <= 1'b0; addr_next <= 1'b0; rd_mode <= 1'b0;
      is_addr <= 1'b0; is_rd <= 1'b0; addr_rw <= 1'b0; ackbit <= 1'b1;
      data_r <= 8'h00; tx <= 8'h00; shin <= 8'h00; status <= C_IDLE;
    end else if (wr_rst) begin
      st <= IDLE; ph <= 2'd0; bitn <= 4'd0;
      sta <= 1'b0; sto <= 1'b0; flag <= 1'b0;
      scl_lo <= 1'b0; sda_lo <= 1'b0;
      addr_next <= 1'b0; rd_mode <= 1'b0; status <= C_IDLE;
    end else begin
      if (wr_ctl) begin
        en <= wdata[B_EN]; sta <= wdata[B_STA]; sto <= wdata[B_STO]; ack_en <= wdata[B_ACK];
        if (wdata[B_FLG]) flag <= 1'b0;
      end
      if (wr_dat) data_r <= wdata;

      if (!en && st != IDLE) begin
        st <= IDLE; scl_lo <= 1'b0; sda_lo <= 1'b0; flag <= 1'b0;
        addr_next <= 1'b0; rd_mode <= 1'b0; status <= C_IDLE;
      end else begin
        case (st)
          IDLE: begin
            scl_lo <= 1'b0; sda_lo <= 1'b0;
            if (en && sta) begin st <= GEN_START; ph <= 2'd0; rep <= 1'b0; end
          end
          HOLD: if (!flag) begin
            ph <= 2'd0;
            if (sto) begin
              st <= GEN_STOP; sda_lo <= 1'b1;
            end else if (sta) begin
              st <= GEN_START; rep <= 1'b1; sda_lo <= 1'b0;
            end else begin
              st <= XFER; bitn <= 4'd0; tx <= data_r;
              is_addr <= addr_next; addr_rw <= data_r[0];
              is_rd <= rd_mode && !addr_next;
              sda_lo <= (rd_mode && !addr_next) ? 1'b0 : ~data_r[7];
            end
          end
          GEN_START: if (adv) begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: scl_lo <= 1'b0;
              2'd1: sda_lo <= 1'b1;
              2'd2: scl_lo <= 1'b1;
              default: begin
                st <= HOLD; flag <= 1'b1; sta <= 1'b0;
                status <= rep ? C_RSTART : C_START;
                addr_next <= 1'b1; rd_mode <= 1'b0;
              end
            endcase
          end
          GEN_STOP: if (adv) begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: scl_lo <= 1'b0;
              2'd1: ;
              2'd2: sda_lo <= 1'b0;
              default: begin
                st <= IDLE; sto <= 1'b0; status <= C_IDLE;
                addr_next <= 1'b0; rd_mode <= 1'b0;
              end
            endcase
          end
          XFER: if (adv) begin
            ph <= ph + 2'd1;
            case (ph)
              2'd0: scl_lo <= 1'b0;
              2'd1: begin
                if (bitn == LAST_BIT) ackbit <= sda_in;
                else shin <= {shin[6:0], sda_in};
              end
              2'd2: scl_lo <= 1'b1;
              default: begin
                if (bitn == LAST_BIT) begin
                  st <= HOLD; flag <= 1'b1; status <= done_code; addr_next <= 1'b0;
                  if (is_addr) rd_mode <= addr_rw && !ackbit;
                  if (is_rd) data_r <= shin;
                end else begin
                  bitn <= bitn + 4'd1;
                  tx <= {tx[6:0], 1'b0};
                  if (bitn == LAST_BIT - 4'd1) sda_lo <= is_rd ? ack_en : 1'b0;
                  else sda_lo <= is_rd ? 1'b0 : ~tx[6];
                end
              end
            endcase
          end
          default: st <= IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_step_master_sva.sv
module i2c_step_master_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_sel,
  input logic [7:0] ctrl_out,
  input logic [7:0] status_out,
  input logic       irq,
  input logic       scl_oe,
  input logic       sda_oe
);
  AST_HOLD_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> scl_oe); // R3
  AST_FLAG_NEEDS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ctrl_out[6])); // R10
  AST_SOFT_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd2) |=> (status_out == 8'hF8 && !irq && !scl_oe && !sda_oe)); // R9
  AST_STOP_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctrl_out[4]) && !$past(reg_wr)) |-> (status_out == 8'hF8 && !irq && !scl_oe && !sda_oe)); // R8
  AST_START_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ctrl_out[5]) && !$past(reg_wr)) |-> (irq && (status_out == 8'h08 || status_out == 8'h10))); // R2
  AST_STATUS_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(status_out) && status_out != 8'hF8) |-> irq); // R4
endmodule

bind i2c_step_master i2c_step_master_sva chk (.*);

// File: tb/i2c_step_master_test.sv
`timescale 1ns/1ps
module i2c_step_master_test;
  logic clk = 0, rst_n = 0, tick = 0, reg_wr = 0;
  logic [1:0] reg_sel = 0;
  logic [7:0] wdata = 0;
  logic [7:0] ctrl_out, data_out, status_out;
  logic irq, scl_oe, sda_oe;
  logic s_sda_low = 0, s_scl_low = 0;
  wire scl = ~(scl_oe | s_scl_low);
  wire sda = ~(sda_oe | s_sda_low);

  int checks = 0, errors = 0, start_cnt = 0, stop_cnt = 0;
  int m_left = 0;
  bit m_busy = 0, m_stop = 0, m_flag = 0, run_model = 0;
  logic [7:0] m_status = 8'hF8, m_pend = 8'h00;
  logic [7:0] seen;
  logic ack_low;

  i2c_step_master uut (.clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .wdata(wdata), .ctrl_out(ctrl_out), .data_out(data_out), .status_out(status_out), .irq(irq),
    .scl_oe(scl_oe), .scl_in(scl), .sda_oe(sda_oe), .sda_in(sda));

  always #2.5 clk = ~clk;

  always @(negedge sda) if (scl === 1'b1 && rst_n) start_cnt++;
  always @(posedge sda) if (scl === 1'b1 && rst_n) stop_cnt++;

  // behavioural reference for flag and status
  always @(posedge clk) begin
    if (reg_wr && reg_sel == 2'd2) begin
      m_flag = 0; m_status = 8'hF8; m_busy = 0;
    end else begin
      if (reg_wr && reg_sel == 2'd0 && wdata[3]) m_flag = 0;
      if (m_busy && tick && !s_scl_low) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0;
          if (m_stop) m_status = 8'hF8;
          else begin m_flag = 1; m_status = m_pend; end
        end
      end
    end
  end

  always @(negedge clk) if (run_model) begin
    checks++;
    if (irq !== m_flag || status_out !== m_status) begin
      errors++;
      $display("FAIL R3/R12 model compare at %0t: irq=%0b status=%h expected irq=%0b status=%h",
               $time, irq, status_out, m_flag, m_status);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = s; wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic pulse();
    @(negedge clk); tick = 0;
    @(negedge clk); tick = 1;
  endtask

  task automatic arm(input logic [7:0] exp, input int n, input bit stp);
    m_pend = exp; m_left = n; m_stop = stp; m_busy = 1;
  endtask

  task automatic cond(input logic [7:0] ctl, input bit stp, input logic [7:0] exp);
    wr(0, ctl);
    arm(exp, 4, stp);
    for (int i = 0; i < 4; i++) pulse();
    @(negedge clk); tick = 0;
    @(negedge clk);
  endtask

  task automatic xbyte(input logic [7:0] ctl, input logic [7:0] tx, input bit rd, input logic [7:0] rx,
                       input bit s_ack, input logic [7:0] exp, input bit stretch, input bit collide);
    if (!rd) wr(1, tx);
    wr(0, ctl);
    arm(exp, 36, 0);
    for (int i = 1; i <= 36; i++) begin
      int b = (i - 1) / 4;
      int p = (i - 1) % 4;
      @(negedge clk); tick = 0;
      if (p == 0) s_sda_low = (b < 8) ? (rd ? ~rx[7-b] : 1'b0) : (rd ? 1'b0 : s_ack);
      if (p == 1) begin
        if (stretch && b == 2) begin
          s_scl_low = 1;
          for (int k = 0; k < 3; k++) pulse();
          @(negedge clk); tick = 0; s_scl_low = 0;
        end
        if (b < 8) seen[7-b] = sda; else ack_low = !sda;
      end
      @(negedge clk); tick = 1;
      if (collide && i == 36) begin reg_wr = 1; reg_sel = 0; wdata = ctl; end
    end
    @(negedge clk); tick = 0; reg_wr = 0; s_sda_low = 0;
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(status_out == 8'hF8, "R1 status", status_out, 8'hF8);
    check(!irq && ctrl_out == 8'h00, "R1 flag/ctrl", ctrl_out, 0);
    check(!scl_oe && !sda_oe, "R1 lines", {scl_oe, sda_oe}, 0);
    run_model = 1;

    // R10: bus disabled, START request ignored
    wr(0, 8'h20);
    for (int i = 0; i < 6; i++) pulse();
    @(negedge clk); tick = 0;
    check(!irq && status_out == 8'hF8, "R10 no step", status_out, 8'hF8);
    check(!scl_oe && !sda_oe && start_cnt == 0, "R10 lines", start_cnt, 0);

    // R2: START
    cond(8'h60, 0, 8'h08);
    check(start_cnt == 1, "R2 start edge", start_cnt, 1);
    check(ctrl_out[5] == 0 && irq, "R2 start bit clear", ctrl_out, 8'h48);
    check(scl_oe && sda_oe, "R2 lines held", {scl_oe, sda_oe}, 3);

    // R4: write address acknowledged
    xbyte(8'h48, 8'hA0, 0, 0, 1, 8'h18, 0, 0);
    check(seen == 8'hA0, "R4 address bits", seen, 8'hA0);
    check(status_out == 8'h18, "R4 status 18", status_out, 8'h18);

    // R3: writing 0 to flag keeps the bus held
    wr(0, 8'h40);
    for (int i = 0; i < 5; i++) pulse();
    @(negedge clk); tick = 0;
    check(irq && scl_oe && status_out == 8'h18, "R3 flag kept", {irq, scl_oe}, 3);

    // R5: data write ack and nack
    xbyte(8'h48, 8'h3C, 0, 0, 1, 8'h28, 0, 0);
    check(seen == 8'h3C && status_out == 8'h28, "R5 write ack", seen, 8'h3C);
    xbyte(8'h48, 8'hC5, 0, 0, 0, 8'h30, 0, 0);
    check(seen == 8'hC5 && status_out == 8'h30, "R5 write nack", seen, 8'hC5);

    // R7: repeated START
    cond(8'h68, 0, 8'h10);
    check(start_cnt == 2 && stop_cnt == 0 && status_out == 8'h10, "R7 repeated start", start_cnt, 2);

    // R4: read address acknowledged
    xbyte(8'h48, 8'hA1, 0, 0, 1, 8'h40, 0, 0);
    check(seen == 8'hA1 && status_out == 8'h40, "R4 read address", seen, 8'hA1);

    // R6 + R11: read with ack, slave stretches SCL
    xbyte(8'h4C, 8'h00, 1, 8'h9B, 0, 8'h50, 1, 0);
    check(data_out == 8'h9B, "R6 read data", data_out, 8'h9B);
    check(ack_low && status_out == 8'h50, "R6/R11 ack sent", ack_low, 1);

    // R6 + R12: final read with nack, flag clear collides with completion
    xbyte(8'h48, 8'h00, 1, 8'h27, 0, 8'h58, 0, 1);
    check(data_out == 8'h27 && !ack_low, "R6 nack byte", data_out, 8'h27);
    check(irq == 1, "R12 flag set wins", irq, 1);

    // R8: STOP
    cond(8'h58, 1, 8'hF8);
    check(stop_cnt == 1 && ctrl_out[4] == 0, "R8 stop edge/self clear", stop_cnt, 1);
    check(!scl_oe && !sda_oe && !irq && status_out == 8'hF8, "R8 idle", status_out, 8'hF8);

    // R4: write address not acknowledged, then STOP
    cond(8'h60, 0, 8'h08);
    xbyte(8'h48, 8'hA0, 0, 0, 0, 8'h20, 0, 0);
    check(status_out == 8'h20, "R4 status 20", status_out, 8'h20);
    cond(8'h58, 1, 8'hF8);

    // R4: read address not acknowledged
    cond(8'h60, 0, 8'h08);
    xbyte(8'h48, 8'hA1, 0, 0, 0, 8'h48, 0, 0);
    check(status_out == 8'h48, "R4 status 48", status_out, 8'h48);

    // R9: soft reset in the middle of a byte
    wr(1, 8'h55);
    wr(0, 8'h48);
    arm(8'h28, 36, 0);
    for (int i = 0; i < 10; i++) pulse();
    @(negedge clk); tick = 0;
    wr(2, 8'h00);
    check(status_out == 8'hF8 && !irq, "R9 status", status_out, 8'hF8);
    check(!scl_oe && !sda_oe && ctrl_out[5:3] == 3'b000, "R9 lines/ctrl", ctrl_out, 8'h40);
    for (int i = 0; i < 4; i++) pulse();
    @(negedge clk); tick = 0;
    check(!irq && !scl_oe && !sda_oe, "R9 stays idle", {scl_oe, sda_oe}, 0);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule